// File: doc/BRIEF.md
# Port 80h Capture Ring Buffer

This block logs host writes to the port 80h progress-code address into a small circular byte store. The host side sees only a write strobe and a data byte. The embedded CPU programs three index registers and a control register through a simple configuration strobe interface: the lower and upper bounds of the circular window, and the position of the newest entry. The CPU can read any stored byte through a separate read port.

Each accepted write first moves the current index forward, wrapping to the lower bound once it would go past the upper bound, and then stores the byte at the new position. The current index therefore always names the newest entry. Every accepted write also raises an input-full interrupt. The interrupt stays high until firmware clears it with an explicit strobe. Firmware can then walk the ring from its last known position up to the current index and collect every code that arrived since it last looked.

Top module: `p80_ring`

## Requirements
- R1: After reset the control bits are 0, the lower bound is 0, the upper bound is 63, the current index is 0, every stored byte is 0 and `irq` is 0.
- R2: A host write is accepted only when control bit 7 (capture enable) and control bit 6 (accept cycles) are both 1. Otherwise the write is dropped, the current index does not move, no byte is stored and `irq` keeps its value.
- R3: On an accepted write, the current index becomes the old index plus one, and the byte is stored at that new index. Both are visible one cycle after the strobe.
- R4: If the old current index plus one (computed without truncation) is greater than the upper bound, the new current index is the lower bound instead.
- R5: An accepted write sets `irq`. `irq` then holds until `irq_clr` is pulsed. If an accepted write and `irq_clr` arrive in the same cycle, `irq` ends up set.
- R6: `rd_data` returns, in the same cycle, the byte stored at `rd_addr`, for any of the 64 indices.
- R7: A configuration write uses `cfg_sel` to pick the target: 0 for control, 1 for the lower bound, 2 for the upper bound, 3 for the current index. An index keeps the low 6 bits of the written value, and the control register keeps only bits 7 and 6. `cfg_rdata` returns the selected register in the same cycle, with every unused bit reading 0.
- R8: A configuration write to the current index wins over a host write in the same cycle. The index takes the written value, the host byte is not stored and `irq` is not set by it.
- R9: `cur_idx` always shows the current index register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | One-cycle strobe for a host write to port 80h |
| host_data | input | 8 | Byte carried by the host write |
| cfg_wr | input | 1 | Configuration register write strobe |
| cfg_sel | input | 2 | Register select: 0 control, 1 lower bound, 2 upper bound, 3 current index |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Selected configuration register, combinational |
| irq_clr | input | 1 | Clears the input-full interrupt |
| irq | output | 1 | Input-full interrupt |
| cur_idx | output | 6 | Current (newest) ring index |
| rd_addr | input | 6 | CPU read index into the ring |
| rd_data | output | 8 | Byte stored at `rd_addr` |

## Verification
The in-RTL properties check the following on every cycle: the index holds still when a write is refused, it steps by exactly one or falls back to the lower bound, a current-index write takes its value, a stored byte lands where it was addressed, and the interrupt's set, clear and hold behaviour. Only the bench's scenarios can show the following: the right bytes sit at the right positions after several wraps; narrow windows and a current index left above the upper bound behave as specified; the read port and the register readback agree with what firmware expects after a long mixed sequence.

// File: rtl/p80_pkg.sv
package p80_pkg;

    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_BEGIN = 2'd1,
        SEL_END   = 2'd2,
        SEL_CUR   = 2'd3
    } cfg_sel_e;

    localparam int CTRL_EN_BIT  = 7;
    localparam int CTRL_ACC_BIT = 6;

endpackage

// File: rtl/p80_idx_regs.sv
module p80_idx_regs
    import p80_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6,
    parameter logic [IDX_W-1:0] BEGIN_RST = '0,
    parameter logic [IDX_W-1:0] END_RST   = {IDX_W{1'b1}},
    parameter logic [IDX_W-1:0] CUR_RST   = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              go_o,
    output logic [IDX_W-1:0]  wr_idx_o,
    output logic [IDX_W-1:0]  cur_o,
    output logic [DATA_W-1:0] cfg_rdata_o
);

    typedef struct packed {
        logic             en;
        logic             acc;
        logic [IDX_W-1:0] beg;
        logic [IDX_W-1:0] fin;
        logic [IDX_W-1:0] cur;
    } idx_st_t;

    idx_st_t          st_d, st_q;
    cfg_sel_e         sel;
    logic             cur_wr;
    logic             go;
    logic [IDX_W:0]   inc;
    logic [IDX_W-1:0] nxt;

    always_comb begin
        sel    = cfg_sel_e'(cfg_sel);
        cur_wr = cfg_wr && (sel == SEL_CUR);
        go     = host_wr && st_q.en && st_q.acc && !cur_wr;
        inc    = {1'b0, st_q.cur} + {{IDX_W{1'b0}}, 1'b1};
        if (inc > {1'b0, st_q.fin}) begin
            nxt = st_q.beg;
        end else begin
            nxt = inc[IDX_W-1:0];
        end

        st_d = st_q;
        if (go) begin
            st_d.cur = nxt;
        end
        if (cfg_wr) begin
            case (sel)
                SEL_CTRL: begin
                    st_d.en  = cfg_wdata[CTRL_EN_BIT];
                    st_d.acc = cfg_wdata[CTRL_ACC_BIT];
                end
                SEL_BEGIN: st_d.beg = cfg_wdata[IDX_W-1:0];
                SEL_END:   st_d.fin = cfg_wdata[IDX_W-1:0];
                SEL_CUR:   st_d.cur = cfg_wdata[IDX_W-1:0];
                default:   st_d = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{en: 1'b0, acc: 1'b0, beg: BEGIN_RST, fin: END_RST, cur: CUR_RST};
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        cfg_rdata_o = '0;
        case (sel)
            SEL_CTRL: begin
                cfg_rdata_o[CTRL_EN_BIT]  = st_q.en;
                cfg_rdata_o[CTRL_ACC_BIT] = st_q.acc;
            end
            SEL_BEGIN: cfg_rdata_o[IDX_W-1:0] = st_q.beg;
            SEL_END:   cfg_rdata_o[IDX_W-1:0] = st_q.fin;
            SEL_CUR:   cfg_rdata_o[IDX_W-1:0] = st_q.cur;
            default:   cfg_rdata_o = '0;
        endcase
    end

    assign go_o     = go;
    assign wr_idx_o = nxt;
    assign cur_o    = st_q.cur;

    // R2: a refused or absent host write leaves the index alone
    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!(host_wr && st_q.en && st_q.acc) && !cur_wr) |=> $stable(st_q.cur));

    // R3: in-window step is exactly one
    p_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ({1'b0, st_q.cur} + 1'b1 <= {1'b0, st_q.fin}))
        |=> (st_q.cur == $past(st_q.cur) + 1'b1));

    // R4: stepping past the upper bound lands on the lower bound
    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (go && ({1'b0, st_q.cur} + 1'b1 > {1'b0, st_q.fin}))
        |=> (st_q.cur == $past(st_q.beg)));

    // R8: a current-index write wins over a host write
    p_curwr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        cur_wr |=> (st_q.cur == $past(cfg_wdata[IDX_W-1:0])));

endmodule

// File: rtl/p80_ring_mem.sv
module p80_ring_mem #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] entry_d [DEPTH];
    logic [DATA_W-1:0] entry_q [DEPTH];

    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_entry
        always_comb begin
            entry_d[gi] = entry_q[gi];
            if (we && (waddr == IDX_W'(gi))) begin
                entry_d[gi] = wdata;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                entry_q[gi] <= '0;
            end else begin
                entry_q[gi] <= entry_d[gi];
            end
        end
    end

    assign rdata = entry_q[raddr];

    // R3: a stored byte lands at the addressed slot
    p_store_r3: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (entry_q[$past(waddr)] == $past(wdata)));

endmodule

// File: rtl/p80_irq_flag.sv
module p80_irq_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic set_i,
    input  logic clr_i,
    output logic irq_o
);

    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (set_i) begin
            flag_d = 1'b1;
        end else if (clr_i) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else begin
            flag_q <= flag_d;
        end
    end

    assign irq_o = flag_q;

    // R5: set wins, clear drops, otherwise hold
    p_irq_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        set_i |=> flag_q);
    p_irq_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i && !set_i) |=> !flag_q);
    p_irq_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr_i && !set_i) |=> $stable(flag_q));

endmodule

// File: rtl/p80_ring.sv
module p80_ring #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_data,
    input  logic              cfg_wr,
    input  logic [1:0]        cfg_sel,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic [DATA_W-1:0] cfg_rdata,
    input  logic              irq_clr,
    output logic              irq,
    output logic [IDX_W-1:0]  cur_idx,
    input  logic [IDX_W-1:0]  rd_addr,
    output logic [DATA_W-1:0] rd_data
);

    localparam logic [IDX_W-1:0] BEGIN_RST = '0;
    localparam logic [IDX_W-1:0] END_RST   = {IDX_W{1'b1}};
    localparam logic [IDX_W-1:0] CUR_RST   = '0;

    logic             go;
    logic [IDX_W-1:0] wr_idx;

    p80_idx_regs #(
        .DATA_W    (DATA_W),
        .IDX_W     (IDX_W),
        .BEGIN_RST (BEGIN_RST),
        .END_RST   (END_RST),
        .CUR_RST   (CUR_RST)
    ) u_idx (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_wr     (host_wr),
        .cfg_wr      (cfg_wr),
        .cfg_sel     (cfg_sel),
        .cfg_wdata   (cfg_wdata),
        .go_o        (go),
        .wr_idx_o    (wr_idx),
        .cur_o       (cur_idx),
        .cfg_rdata_o (cfg_rdata)
    );

    p80_ring_mem #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_mem (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (go),
        .waddr (wr_idx),
        .wdata (host_data),
        .raddr (rd_addr),
        .rdata (rd_data)
    );

    p80_irq_flag u_irq (
        .clk   (clk),
        .rst_n (rst_n),
        .set_i (go),
        .clr_i (irq_clr),
        .irq_o (irq)
    );

    // R9 / R3: after an accepted write the newest entry sits at cur_idx
    p_newest_r9: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> (cur_idx == $past(wr_idx)));

endmodule

// File: tb/p80_ring_tb.sv
module p80_ring_tb;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_wr = 1'b0;
    logic [7:0] host_data = '0;
    logic       cfg_wr = 1'b0;
    logic [1:0] cfg_sel = '0;
    logic [7:0] cfg_wdata = '0;
    logic [7:0] cfg_rdata;
    logic       irq_clr = 1'b0;
    logic       irq;
    logic [5:0] cur_idx;
    logic [5:0] rd_addr = '0;
    logic [7:0] rd_data;

    always #10 clk = ~clk;

    p80_ring u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_wr   (host_wr),
        .host_data (host_data),
        .cfg_wr    (cfg_wr),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .cfg_rdata (cfg_rdata),
        .irq_clr   (irq_clr),
        .irq       (irq),
        .cur_idx   (cur_idx),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data)
    );

    int    n_vec = 0;
    int    n_bad = 0;
    bit    done = 0;
    string req = "R1";

    int m_en, m_acc, m_beg, m_end, m_cur, m_irq;
    int m_mem [64];
    int probe = 0;

    task automatic chk(string tag, int act, int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, tag, act, exp);
        end
    endtask

    function automatic int exp_rdata(int sel);
        case (sel)
            0:       return (m_en << 7) | (m_acc << 6);
            1:       return m_beg;
            2:       return m_end;
            default: return m_cur;
        endcase
    endfunction

    task automatic model_step();
        bit cur_wr, go;
        int n;
        cur_wr = cfg_wr && (cfg_sel == 2'd3);
        go = host_wr && (m_en != 0) && (m_acc != 0) && !cur_wr;
        if (go) begin
            n = m_cur + 1;
            if (n > m_end) n = m_beg;
            m_mem[n] = host_data;
            m_cur = n;
            m_irq = 1;
        end else if (irq_clr) begin
            m_irq = 0;
        end
        if (cfg_wr) begin
            case (cfg_sel)
                2'd0: begin m_en = cfg_wdata[7]; m_acc = cfg_wdata[6]; end
                2'd1: m_beg = cfg_wdata & 8'h3f;
                2'd2: m_end = cfg_wdata & 8'h3f;
                default: m_cur = cfg_wdata & 8'h3f;
            endcase
        end
    endtask

    task automatic compare();
        rd_addr = 6'(probe);
        probe = (probe + 7) % 64;
        #1;
        chk("cur_idx", cur_idx, m_cur);
        chk("irq", irq, m_irq);
        chk("rd_data", rd_data, m_mem[rd_addr]);
        chk("cfg_rdata", cfg_rdata, exp_rdata(cfg_sel));
    endtask

    task automatic cyc();
        model_step();
        @(posedge clk);
        @(negedge clk);
        host_wr = 0; cfg_wr = 0; irq_clr = 0;
        compare();
    endtask

    task automatic hw(input int d);
        host_wr = 1; host_data = 8'(d);
        cyc();
    endtask

    task automatic cw(input int sel, input int d);
        cfg_wr = 1; cfg_sel = 2'(sel); cfg_wdata = 8'(d);
        cyc();
    endtask

    task automatic read_at(input int a, input int exp);
        rd_addr = 6'(a);
        #1;
        chk("rd_data sweep", rd_data, exp);
    endtask

    task automatic summary();
        $display("  == %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        m_en = 0; m_acc = 0; m_beg = 0; m_end = 63; m_cur = 0; m_irq = 0;
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 / R9: reset values
        req = "R1";
        for (int s = 0; s < 4; s++) begin
            cfg_sel = 2'(s);
            compare();
        end

        // R2: dropped with neither, one or the other bit set
        req = "R2";
        hw(8'h11);
        cw(0, 8'h80); hw(8'h22);
        cw(0, 8'h40); hw(8'h33);
        chk("idx after refused writes", cur_idx, 0);

        // R7: register masking and readback
        req = "R7";
        cw(0, 8'hFF); cfg_sel = 2'd0; compare();
        chk("ctrl readback", cfg_rdata, 8'hC0);
        cw(1, 8'hC5); cfg_sel = 2'd1; compare();
        cw(1, 8'h00);
        cw(2, 8'hFF);

        // R3 / R5 / R9: sequential capture, interrupt raise
        req = "R3";
        for (int i = 1; i <= 5; i++) hw(8'h40 + i);
        chk("newest index", cur_idx, 5);
        req = "R6";
        for (int a = 0; a < 8; a++) read_at(a, m_mem[a]);

        req = "R5";
        irq_clr = 1; cyc();
        chk("irq cleared", irq, 0);
        irq_clr = 1; host_wr = 1; host_data = 8'h9A; cyc();
        chk("set beats clear", irq, 1);
        cyc(); cyc();

        // R4: narrow window wrap and top-of-range wrap
        req = "R4";
        cw(1, 10); cw(2, 13); cw(3, 12);
        hw(8'hA1); hw(8'hA2); hw(8'hA3); hw(8'hA4);
        chk("narrow wrap", cur_idx, 12);
        cw(3, 50); hw(8'hB0);
        chk("above-bound wrap", cur_idx, 10);
        cw(1, 0); cw(2, 63); cw(3, 62);
        hw(8'hC1); hw(8'hC2);
        chk("full wrap", cur_idx, 0);

        // R8: index write wins over host write
        req = "R8";
        irq_clr = 1; cyc();
        cfg_wr = 1; cfg_sel = 2'd3; cfg_wdata = 8'd20;
        host_wr = 1; host_data = 8'hEE; cyc();
        chk("index forced", cur_idx, 20);
        chk("no irq", irq, 0);
        read_at(21, m_mem[21]);

        // Mixed random traffic over all requirements
        req = "R6";
        for (int k = 0; k < 400; k++) begin
            host_wr   = ($urandom % 3) != 0;
            host_data = 8'($urandom);
            cfg_wr    = ($urandom % 9) == 0;
            cfg_sel   = 2'($urandom);
            cfg_wdata = 8'($urandom);
            if (cfg_sel == 2'd0 && ($urandom % 2) == 0) cfg_wdata[7:6] = 2'b11;
            irq_clr   = ($urandom % 5) == 0;
            cyc();
        end
        for (int a = 0; a < 64; a++) read_at(a, m_mem[a]);

        done = 1;
        summary();
        $finish;
    end

endmodule